// File: doc/BRIEF.md
# Clock Domain Power-Down Sequencer

This controller takes a clock domain that exchanges register values with a partner domain through crossing FIFOs and switches it off and back on in a safe order. To power down, it first withdraws the partner's permission to start transfers. It then waits until no transfer is still in flight, holds the domain in reset, and only then removes power. To power up, it restores power and waits for the supply to report good. It keeps reset applied for a programmable number of cycles, releases it, and finally grants the partner permission again.

The sequencer runs on an always-on control clock. The off and on requests, the in-flight flag, the power-good flag and the hold count are synchronous to that clock. The domain reset and power enable are registered in the control clock. The permission signal is re-timed into the partner clock and registered there. Its partner-side value is synchronised back, and the control logic uses that copy as an acknowledgement. Permission and reset are driven independently; neither one is derived from the other.

Top module: `power_seq_ctrl`

## Requirements
- R1: After `rst_n` is asserted, and for as long as it stays asserted, the outputs are `part_allow`=1, `dom_rst`=0, `pwr_en`=1, `busy`=0 and `drain_err`=0. The block is powered and idle.
- R2: When `off_req` is high in the idle powered state, `busy` goes high at the next clock edge and `part_allow` then falls. `dom_rst` stays low while the returned permission is still high or while `inflight_busy` is high.
- R3: Once the drain completes, `dom_rst` goes high one cycle before `pwr_en` goes low. `pwr_en` is never low while `dom_rst` is low.
- R4: If the drain has not completed after exactly `DRAIN_TIMEOUT` cycles of waiting, `drain_err` goes high. It is visible at the edge `DRAIN_TIMEOUT` cycles after the drain began. The block keeps waiting with reset low. `drain_err` clears at the edge where the drain completes.
- R5: In the powered-off idle state, `pwr_en`=0, `dom_rst`=1, `part_allow`=0 and `busy`=0.
- R6: When `on_req` is high in the powered-off idle state, `pwr_en` and `busy` go high at the next edge. `dom_rst` stays high for as long as `pwr_good` is low.
- R7: After `pwr_good` is sampled high, `dom_rst` stays high for exactly max(`min_hold`,1) more cycles and then falls.
- R8: `part_allow` rises only after `dom_rst` has fallen. `busy` falls only once the permission has returned high, which leaves the block idle and powered.
- R9: `on_req` in the powered idle state, `off_req` in the off idle state, and either request while `busy` is high are all ignored. None of them changes any output.
- R10: `part_allow` is a register clocked by `part_clk` and reset high by `part_rst_n`. The permission passes through `SYNC_STAGES` flops in each direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on control clock |
| rst_n | input | 1 | Control-domain reset, active low, asynchronous assert |
| part_clk | input | 1 | Partner domain clock |
| part_rst_n | input | 1 | Partner domain reset, active low |
| off_req | input | 1 | Request to power the domain down |
| on_req | input | 1 | Request to power the domain up |
| inflight_busy | input | 1 | High while any crossing transfer is unresolved |
| pwr_good | input | 1 | Supply of the domain reports stable |
| min_hold | input | HOLD_W | Minimum reset cycles after power good (0 acts as 1) |
| part_allow | output | 1 | Transfer permission, in the partner clock |
| dom_rst | output | 1 | Domain reset, active high |
| pwr_enable | output | 1 | Power switch enable |
| busy | output | 1 | A sequence is running |
| drain_err | output | 1 | Drain wait has exceeded its timeout |

## Verification
The bench targets the following corner cases:
- **Zero or one hold cycle.** An off-by-one in the hold counter would show up here as a reset that lasts one cycle too long or too short.
- **Drains that outlast the permission handshake.** A design that skipped the in-flight check would assert reset while traffic was still moving.
- **Exact timeout cycle.** The bench checks the flag one cycle before the timeout and on the timeout cycle itself, so an early or late error flag is caught.
- **Mistimed requests.** Requests are placed in the middle of sequences and in the idle state where they have no meaning. A design that honoured them would bounce power or skip steps.
- **Reset mid power-up.** A reset applied partway through power-up must return every output to its powered default.

// File: rtl/psq_pkg.sv
package psq_pkg;

   typedef enum logic [2:0] {
      ST_ON          = 3'd0,
      ST_DRAIN       = 3'd1,
      ST_RST_ASSERT  = 3'd2,
      ST_PWR_OFF     = 3'd3,
      ST_OFF         = 3'd4,
      ST_PWR_ON      = 3'd5,
      ST_RST_RELEASE = 3'd6,
      ST_ALLOW_RAISE = 3'd7
   } psq_state_e;

   typedef struct packed {
      logic allow;
      logic rst;
      logic pwr;
      logic busy;
   } psq_out_t;

   // Output levels that hold while the sequencer sits in a given state.
   function automatic psq_out_t psq_decode(input psq_state_e st);
      psq_out_t o;
      o.allow = (st == ST_ON) || (st == ST_ALLOW_RAISE);
      o.rst   = (st == ST_RST_ASSERT) || (st == ST_PWR_OFF) || (st == ST_OFF) ||
                (st == ST_PWR_ON) || (st == ST_RST_RELEASE);
      o.pwr   = !((st == ST_PWR_OFF) || (st == ST_OFF));
      o.busy  = !((st == ST_ON) || (st == ST_OFF));
      return o;
   endfunction

endpackage

// File: rtl/psq_sync.sv
module psq_sync #(
   parameter int   STAGES    = 2,
   parameter logic RESET_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   generate
      if (STAGES < 1) begin : g_bad_stages
         $error("psq_sync: STAGES must be at least 1");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   genvar gi;
   generate
      for (gi = 0; gi < STAGES; gi++) begin : g_stage
         if (gi == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= RESET_VAL;
               else        chain[0] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[gi] <= RESET_VAL;
               else        chain[gi] <= chain[gi-1];
            end
         end
      end
   endgenerate

   assign q = chain[STAGES-1];

endmodule

// File: rtl/psq_timer.sv
module psq_timer #(
   parameter int W   = 8,
   parameter int MAX = 255
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clear,
   input  logic         en,
   output logic [W-1:0] count
);

   localparam logic [W-1:0] LIMIT = W'(MAX);

   generate
      if (MAX >= (2 ** W)) begin : g_bad_max
         $error("psq_timer: MAX does not fit in W bits");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      count <= '0;
      else if (clear)                  count <= '0;
      else if (en && (count != LIMIT)) count <= count + 1'b1;
   end

endmodule

// File: rtl/psq_allow_bridge.sv
module psq_allow_bridge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic part_clk,
   input  logic part_rst_n,
   input  logic allow_req,
   output logic part_allow,
   output logic allow_ack
);

   logic req_in_part;

   // Control-to-partner direction: re-time the request, then register it in the partner clock.
   psq_sync #(.STAGES(STAGES), .RESET_VAL(1'b1)) u_fwd (
      .clk   (part_clk),
      .rst_n (part_rst_n),
      .d     (allow_req),
      .q     (req_in_part)
   );

   always_ff @(posedge part_clk or negedge part_rst_n) begin
      if (!part_rst_n) part_allow <= 1'b1;
      else             part_allow <= req_in_part;
   end

   // Partner-to-control direction: the level actually presented to the partner.
   psq_sync #(.STAGES(STAGES), .RESET_VAL(1'b1)) u_back (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (part_allow),
      .q     (allow_ack)
   );

endmodule

// File: rtl/power_seq_ctrl.sv
module power_seq_ctrl
   import psq_pkg::*;
#(
   parameter int SYNC_STAGES   = 2,
   parameter int HOLD_W        = 8,
   parameter int DRAIN_TIMEOUT = 256
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              part_clk,
   input  logic              part_rst_n,
   input  logic              off_req,
   input  logic              on_req,
   input  logic              inflight_busy,
   input  logic              pwr_good,
   input  logic [HOLD_W-1:0] min_hold,
   output logic              part_allow,
   output logic              dom_rst,
   output logic              pwr_enable,
   output logic              busy,
   output logic              drain_err
);

   localparam int TO_W     = $clog2(DRAIN_TIMEOUT + 1);
   localparam int HOLD_MAX = (2 ** HOLD_W) - 1;
   localparam logic [TO_W-1:0] TO_LAST = TO_W'(DRAIN_TIMEOUT - 1);

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("power_seq_ctrl: SYNC_STAGES must be at least 2");
      end
      if (DRAIN_TIMEOUT < 2) begin : g_bad_timeout
         $error("power_seq_ctrl: DRAIN_TIMEOUT must be at least 2");
      end
      if (HOLD_W < 1 || HOLD_W > 16) begin : g_bad_hold
         $error("power_seq_ctrl: HOLD_W must be in 1..16");
      end
   endgenerate

   psq_state_e state, state_nx;
   psq_out_t   outs_nx;
   logic       allow_req;
   logic       allow_ack;
   logic [TO_W-1:0]   to_cnt;
   logic [HOLD_W-1:0] hold_cnt;
   logic [HOLD_W-1:0] hold_tgt;
   logic [HOLD_W:0]   hold_next;
   logic              drained;
   logic              hold_done;
   logic              timed_out;

   psq_allow_bridge #(.STAGES(SYNC_STAGES)) u_bridge (
      .clk        (clk),
      .rst_n      (rst_n),
      .part_clk   (part_clk),
      .part_rst_n (part_rst_n),
      .allow_req  (allow_req),
      .part_allow (part_allow),
      .allow_ack  (allow_ack)
   );

   psq_timer #(.W(TO_W), .MAX(DRAIN_TIMEOUT)) u_drain_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (state != ST_DRAIN),
      .en    (1'b1),
      .count (to_cnt)
   );

   psq_timer #(.W(HOLD_W), .MAX(HOLD_MAX)) u_hold_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (state != ST_RST_RELEASE),
      .en    (1'b1),
      .count (hold_cnt)
   );

   // A zero hold request is treated as one cycle.
   assign hold_tgt  = (min_hold == '0) ? HOLD_W'(1) : min_hold;
   assign hold_next = {1'b0, hold_cnt} + {{HOLD_W{1'b0}}, 1'b1};
   assign hold_done = hold_next >= {1'b0, hold_tgt};
   assign drained   = !allow_ack && !inflight_busy;
   assign timed_out = to_cnt >= TO_LAST;

   always_comb begin
      state_nx = state;
      unique case (state)
         ST_ON:          if (off_req)   state_nx = ST_DRAIN;
         ST_DRAIN:       if (drained)   state_nx = ST_RST_ASSERT;
         ST_RST_ASSERT:                 state_nx = ST_PWR_OFF;
         ST_PWR_OFF:                    state_nx = ST_OFF;
         ST_OFF:         if (on_req)    state_nx = ST_PWR_ON;
         ST_PWR_ON:      if (pwr_good)  state_nx = ST_RST_RELEASE;
         ST_RST_RELEASE: if (hold_done) state_nx = ST_ALLOW_RAISE;
         ST_ALLOW_RAISE: if (allow_ack) state_nx = ST_ON;
         default:                       state_nx = ST_ON;
      endcase
   end

   assign outs_nx = psq_decode(state_nx);

   // Outputs are registered from the next state so that none of them glitches.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_ON;
         allow_req  <= 1'b1;
         dom_rst    <= 1'b0;
         pwr_enable <= 1'b1;
         busy       <= 1'b0;
         drain_err  <= 1'b0;
      end else begin
         state      <= state_nx;
         allow_req  <= outs_nx.allow;
         dom_rst    <= outs_nx.rst;
         pwr_enable <= outs_nx.pwr;
         busy       <= outs_nx.busy;
         drain_err  <= (state == ST_DRAIN) && (state_nx == ST_DRAIN) && timed_out;
      end
   end

endmodule

// File: rtl/psq_checker.sv
module psq_checker
   import psq_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic       off_req,
   input logic       on_req,
   input logic       inflight_busy,
   input logic       allow_req,
   input logic       allow_ack,
   input psq_state_e state,
   input logic       dom_rst,
   input logic       pwr_enable,
   input logic       busy,
   input logic       drain_err
);

   assert_off_implies_rst_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !pwr_enable |-> dom_rst);

   assert_rst_before_pwr_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pwr_enable) |-> $past(dom_rst));

   assert_drained_before_rst_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dom_rst) |-> ($past(!allow_ack) && $past(!inflight_busy)));

   assert_release_after_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dom_rst) |-> ($past(pwr_enable) && $past(state == ST_RST_RELEASE)));

   assert_allow_after_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(allow_req) |-> !dom_rst);

   assert_err_only_draining_R4: assert property (@(posedge clk) disable iff (!rst_n)
      drain_err |-> (busy && !dom_rst && !allow_req));

   assert_busy_needs_request_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(off_req || on_req));

endmodule

bind power_seq_ctrl psq_checker u_psq_checker (
   .clk           (clk),
   .rst_n         (rst_n),
   .off_req       (off_req),
   .on_req        (on_req),
   .inflight_busy (inflight_busy),
   .allow_req     (allow_req),
   .allow_ack     (allow_ack),
   .state         (state),
   .dom_rst       (dom_rst),
   .pwr_enable    (pwr_enable),
   .busy          (busy),
   .drain_err     (drain_err)
);

// File: tb/tb_power_seq_ctrl.sv
module tb_power_seq_ctrl;

   localparam int CLK_PERIOD  = 10;
   localparam int PCLK_PERIOD = 14;
   localparam int HOLD_W      = 8;
   localparam int TIMEOUT     = 20;

   typedef struct packed {
      logic [7:0] hold;
      logic [7:0] drain_len;
      logic       stray;
      logic [7:0] exp_hold;
   } vec_t;

   localparam vec_t VEC [5] = '{
      '{hold: 8'd0, drain_len: 8'd0,  stray: 1'b0, exp_hold: 8'd1},
      '{hold: 8'd1, drain_len: 8'd2,  stray: 1'b1, exp_hold: 8'd1},
      '{hold: 8'd3, drain_len: 8'd5,  stray: 1'b0, exp_hold: 8'd3},
      '{hold: 8'd7, drain_len: 8'd9,  stray: 1'b1, exp_hold: 8'd7},
      '{hold: 8'd2, drain_len: 8'd14, stray: 1'b1, exp_hold: 8'd2}
   };

   logic clk = 1'b0;
   logic pclk = 1'b0;
   logic rst_n = 1'b0;
   logic prst_n = 1'b0;
   logic off_req = 1'b0;
   logic on_req = 1'b0;
   logic inflight = 1'b0;
   logic pgood = 1'b1;
   logic [HOLD_W-1:0] hold = '0;
   logic part_allow, dom_rst, pwr_enable, busy, drain_err;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;
   always #(PCLK_PERIOD / 2) pclk = ~pclk;

   power_seq_ctrl #(
      .SYNC_STAGES   (2),
      .HOLD_W        (HOLD_W),
      .DRAIN_TIMEOUT (TIMEOUT)
   ) dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .part_clk      (pclk),
      .part_rst_n    (prst_n),
      .off_req       (off_req),
      .on_req        (on_req),
      .inflight_busy (inflight),
      .pwr_good      (pgood),
      .min_hold      (hold),
      .part_allow    (part_allow),
      .dom_rst       (dom_rst),
      .pwr_enable    (pwr_enable),
      .busy          (busy),
      .drain_err     (drain_err)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // Waits at falling edges until the selected output equals val; returns the wait or -1.
   task automatic poll(input int sel, input logic val, input int lim, output int n);
      n = -1;
      for (int i = 1; i <= lim; i++) begin
         logic cur;
         @(negedge clk);
         case (sel)
            0:       cur = part_allow;
            1:       cur = dom_rst;
            2:       cur = pwr_enable;
            default: cur = busy;
         endcase
         if (cur === val) begin
            n = i;
            break;
         end
      end
   endtask

   task automatic pulse_off();
      off_req = 1'b1;
      @(negedge clk);
      off_req = 1'b0;
   endtask

   task automatic pulse_on();
      on_req = 1'b1;
      @(negedge clk);
      on_req = 1'b0;
   endtask

   task automatic expect_idle_on(input string req);
      chk(req, "part_allow", int'(part_allow), 1);
      chk(req, "dom_rst", int'(dom_rst), 0);
      chk(req, "pwr_enable", int'(pwr_enable), 1);
      chk(req, "busy", int'(busy), 0);
   endtask

   task automatic power_down(input int drain_len, input bit stray);
      int n;
      inflight = 1'b1;
      pulse_off();
      chk("R2", "busy after off_req", int'(busy), 1);
      poll(0, 1'b0, 40, n);
      chk("R2", "part_allow fell", int'(n > 0), 1);
      if (stray) pulse_on();  // R9: ignored while busy
      for (int i = 0; i < drain_len; i++) begin
         @(negedge clk);
         chk("R2", "dom_rst low while in flight", int'(dom_rst), 0);
      end
      inflight = 1'b0;
      poll(1, 1'b1, 10, n);
      chk("R3", "dom_rst rose", int'(n > 0), 1);
      chk("R3", "power still on at reset", int'(pwr_enable), 1);
      @(negedge clk);
      chk("R3", "power off after reset", int'(pwr_enable), 0);
      @(negedge clk);
      pgood = 1'b0;
      chk("R5", "busy in off", int'(busy), 0);
      chk("R5", "dom_rst in off", int'(dom_rst), 1);
      chk("R5", "part_allow in off", int'(part_allow), 0);
   endtask

   task automatic power_up(input logic [7:0] h, input int exp_h, input bit stray);
      int n;
      hold = h;
      pulse_on();
      chk("R6", "pwr_enable after on_req", int'(pwr_enable), 1);
      chk("R6", "busy after on_req", int'(busy), 1);
      if (stray) pulse_off();  // R9: ignored while busy
      repeat (3) @(negedge clk);
      chk("R6", "reset held without pwr_good", int'(dom_rst), 1);
      pgood = 1'b1;
      n = 0;
      for (int i = 0; i < 300; i++) begin
         @(negedge clk);
         if (dom_rst) n++;
         else break;
      end
      chk("R7", "reset hold cycles", n, exp_h);
      chk("R8", "part_allow low at release", int'(part_allow), 0);
      poll(3, 1'b0, 40, n);
      chk("R8", "sequence finished", int'(n > 0), 1);
      chk("R8", "part_allow back high", int'(part_allow), 1);
      expect_idle_on("R8");
   endtask

   initial begin
      int n;
      #1;
      chk("R1", "dom_rst in reset", int'(dom_rst), 0);
      repeat (3) @(negedge clk);
      expect_idle_on("R1");
      chk("R1", "drain_err in reset", int'(drain_err), 0);
      rst_n = 1'b1;
      prst_n = 1'b1;
      repeat (4) @(negedge clk);
      expect_idle_on("R1");
      chk("R10", "partner allow after reset", int'(part_allow), 1);

      // R9: power-up request while already on
      pulse_on();
      repeat (2) @(negedge clk);
      expect_idle_on("R9");

      foreach (VEC[k]) begin
         power_down(int'(VEC[k].drain_len), VEC[k].stray);
         // R9: power-down request while already off
         pulse_off();
         repeat (2) @(negedge clk);
         chk("R9", "off_req in off ignored busy", int'(busy), 0);
         chk("R9", "off_req in off ignored pwr", int'(pwr_enable), 0);
         power_up(VEC[k].hold, int'(VEC[k].exp_hold), VEC[k].stray);
      end

      // R4: drain timeout, exact cycle
      inflight = 1'b1;
      pulse_off();
      for (int j = 1; j < TIMEOUT; j++) @(negedge clk);
      chk("R4", "no error before timeout", int'(drain_err), 0);
      @(negedge clk);
      chk("R4", "error at timeout", int'(drain_err), 1);
      repeat (5) @(negedge clk);
      chk("R4", "still waiting, reset low", int'(dom_rst), 0);
      chk("R4", "still busy", int'(busy), 1);
      inflight = 1'b0;
      poll(1, 1'b1, 10, n);
      chk("R4", "drain completes late", int'(n > 0), 1);
      chk("R4", "error cleared", int'(drain_err), 0);
      repeat (2) @(negedge clk);
      pgood = 1'b0;

      // R1: reset during power-up returns the defaults
      hold = 8'd50;
      pulse_on();
      pgood = 1'b1;
      repeat (4) @(negedge clk);
      chk("R1", "mid power-up reset held", int'(dom_rst), 1);
      rst_n = 1'b0;
      prst_n = 1'b0;
      #1;
      chk("R1", "async reset drops dom_rst", int'(dom_rst), 0);
      repeat (2) @(negedge clk);
      expect_idle_on("R1");
      rst_n = 1'b1;
      prst_n = 1'b1;
      repeat (3) @(negedge clk);
      expect_idle_on("R1");

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=expired expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule